// File: doc/BRIEF.md
# Memory Traffic Performance Counter Bank

This block watches a DRAM controller and tallies four kinds of events: read bursts, write bursts, row activates and idle cycles. Each event arrives as a single-cycle pulse in the monitor clock domain. Next to the event counters runs an elapsed-time counter, which gives software a time base for working out bandwidth or occupancy ratios.

Software reaches the bank through a plain 32-bit register port. A write is a one-cycle strobe carrying an address and data. Read data is a combinational function of the address. One control register starts and stops every counter together. A configuration register enables each event counter on its own. Overflow flags are sticky, and a clear register takes a write-one mask that zeroes chosen counters along with their flags.

Counters keep their values while the bank is stopped. Software can therefore stop the bank, read the counters, clear some of them and start again.

Top module: `dram_perf_monitor`

## Requirements
- R1: After reset, every counter, every overflow flag, the run state and all enable bits are 0.
- R2: A write to offset 0x000 with bit 0 set starts counting, and with bit 1 set stops it. If both bits are set, stop wins. Bit 0 of a read at 0x000 shows the run state.
- R3: Bits 3..0 of offset 0x004 enable event counters 3..0, in the order read (0), write (1), activate (2), idle (3). These bits read back as written, and all other bits read 0.
- R4: The time counter, read at offset 0x020, increments on every clock while running, whatever the enables hold.
- R5: Event counter n, read at offset 0x030 + 8*n, increments only when the bank is running, enable n is set and event pulse n is high.
- R6: While the bank is stopped, every counter holds its value.
- R7: When a counter wraps from all ones to 0, its flag in the status register at offset 0x008 is set and stays set. Bit n flags event counter n and bit 31 flags the time counter.
- R8: Offset 0x00C is write-one-to-clear. Bits 0..3 zero event counters 0..3 and bit 31 zeroes the time counter, each together with its overflow flag. A 0 bit leaves its counter untouched.
- R9: When a clear and an increment of the same counter fall in the same cycle, the clear wins and the counter reads 0 afterwards.
- R10: Constant registers read as follows: 0x3FC returns 0xA3C5DD01; 0x3F0 returns the event count in bits 7..0 and the counter width in bits 15..8; 0x3F4 returns 0x00000100; 0x3F8 returns 0x00000DD5.
- R11: Writes to offsets 0x010 through 0x018 change nothing, and reads there return 0. Any other unmapped offset also reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Monitor clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 10 | Byte offset for reads and writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| ev_pulse | input | NUM_EVT | Event pulses: read, write, activate, idle |

## Verification
Two things can hit the same counter in one cycle: a clear-register write and an increment, whether that increment comes from a pulse or from the running time counter. The bench provokes this in two ways. A directed step clears a single counter while its pulse is held high. Random stimulus also mixes clear writes with pulses and start and stop commands. A bench model gives priority to the clear, and every readback is compared against that model. A literal check confirms that the cleared counter reads 0 and that its overflow flag has dropped, while the counters beside it keep counting.

// File: rtl/dpm_pkg.sv
package dpm_pkg;
    localparam int ADDR_W = 10;
    localparam int DATA_W = 32;

    localparam logic [ADDR_W-1:0] OFF_CTL   = 10'h000;
    localparam logic [ADDR_W-1:0] OFF_CFG   = 10'h004;
    localparam logic [ADDR_W-1:0] OFF_STAT  = 10'h008;
    localparam logic [ADDR_W-1:0] OFF_CLR   = 10'h00C;
    localparam logic [ADDR_W-1:0] OFF_TCNT  = 10'h020;
    localparam int                OFF_CNT0  = 'h030;
    localparam int                CNT_STEP  = 8;
    localparam logic [ADDR_W-1:0] OFF_HWCFG = 10'h3F0;
    localparam logic [ADDR_W-1:0] OFF_VER   = 10'h3F4;
    localparam logic [ADDR_W-1:0] OFF_IDNT  = 10'h3F8;
    localparam logic [ADDR_W-1:0] OFF_SIG   = 10'h3FC;

    localparam int CTL_START_BIT = 0;
    localparam int CTL_STOP_BIT  = 1;
    localparam int TIME_BIT      = 31;

    localparam logic [DATA_W-1:0] SIG_VAL  = 32'hA3C5_DD01;
    localparam logic [DATA_W-1:0] VER_VAL  = 32'h0000_0100;
    localparam logic [DATA_W-1:0] IDNT_VAL = 32'h0000_0DD5;
endpackage

// File: rtl/dpm_counter.sv
module dpm_counter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    input  logic         clr,
    output logic [W-1:0] cnt,
    output logic         ovf
);
    typedef struct packed {
        logic [W-1:0] cnt;
        logic         ovf;
    } cnt_state_t;

    cnt_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr) begin
            st_d.cnt = '0;
            st_d.ovf = 1'b0;
        end else if (inc) begin
            st_d.cnt = st_q.cnt + 1'b1;
            if (&st_q.cnt) begin
                st_d.ovf = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt = st_q.cnt;
    assign ovf = st_q.ovf;
endmodule

// File: rtl/dpm_ctrl.sv
module dpm_ctrl
    import dpm_pkg::*;
#(
    parameter int NUM_EVT = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_ctl,
    input  logic               wr_cfg,
    input  logic [DATA_W-1:0]  wdata,
    output logic               run,
    output logic [NUM_EVT-1:0] en
);
    typedef struct packed {
        logic               run;
        logic [NUM_EVT-1:0] en;
    } ctrl_state_t;

    ctrl_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_ctl) begin
            if (wdata[CTL_START_BIT]) begin
                st_d.run = 1'b1;
            end
            if (wdata[CTL_STOP_BIT]) begin
                st_d.run = 1'b0;
            end
        end
        if (wr_cfg) begin
            st_d.en = wdata[NUM_EVT-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign run = st_q.run;
    assign en  = st_q.en;
endmodule

// File: rtl/dram_perf_monitor.sv
module dram_perf_monitor
    import dpm_pkg::*;
#(
    parameter int NUM_EVT = 4,
    parameter int CNT_W   = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_wr,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [DATA_W-1:0]  bus_wdata,
    output logic [DATA_W-1:0]  bus_rdata,
    input  logic [NUM_EVT-1:0] ev_pulse
);
    localparam logic [DATA_W-1:0] HWCFG_VAL = DATA_W'(NUM_EVT) | (DATA_W'(CNT_W) << 8);

    logic               wr_ctl, wr_cfg, wr_clr;
    logic               run;
    logic [NUM_EVT-1:0] en;
    logic [CNT_W-1:0]   time_cnt;
    logic               time_ovf;
    logic [CNT_W-1:0]   ev_cnt [NUM_EVT];
    logic [NUM_EVT-1:0] ev_ovf;

    assign wr_ctl = bus_wr && (bus_addr == OFF_CTL);
    assign wr_cfg = bus_wr && (bus_addr == OFF_CFG);
    assign wr_clr = bus_wr && (bus_addr == OFF_CLR);

    dpm_ctrl #(.NUM_EVT(NUM_EVT)) u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_ctl (wr_ctl),
        .wr_cfg (wr_cfg),
        .wdata  (bus_wdata),
        .run    (run),
        .en     (en)
    );

    dpm_counter #(.W(CNT_W)) u_time (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (run),
        .clr   (wr_clr && bus_wdata[TIME_BIT]),
        .cnt   (time_cnt),
        .ovf   (time_ovf)
    );

    for (genvar gi = 0; gi < NUM_EVT; gi++) begin : g_evt
        dpm_counter #(.W(CNT_W)) u_evt (
            .clk   (clk),
            .rst_n (rst_n),
            .inc   (run && en[gi] && ev_pulse[gi]),
            .clr   (wr_clr && bus_wdata[gi]),
            .cnt   (ev_cnt[gi]),
            .ovf   (ev_ovf[gi])
        );
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            OFF_CTL:   bus_rdata[0] = run;
            OFF_CFG:   bus_rdata[NUM_EVT-1:0] = en;
            OFF_STAT: begin
                bus_rdata[TIME_BIT]    = time_ovf;
                bus_rdata[NUM_EVT-1:0] = ev_ovf;
            end
            OFF_TCNT:  bus_rdata = DATA_W'(time_cnt);
            OFF_HWCFG: bus_rdata = HWCFG_VAL;
            OFF_VER:   bus_rdata = VER_VAL;
            OFF_IDNT:  bus_rdata = IDNT_VAL;
            OFF_SIG:   bus_rdata = SIG_VAL;
            default:   bus_rdata = '0;
        endcase
        for (int i = 0; i < NUM_EVT; i++) begin
            if (bus_addr == ADDR_W'(OFF_CNT0 + CNT_STEP * i)) begin
                bus_rdata = DATA_W'(ev_cnt[i]);
            end
        end
    end
endmodule

// File: rtl/dpm_checker.sv
module dpm_checker
    import dpm_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              run,
    input logic [CNT_W-1:0]  tcnt,
    input logic              tovf
);
    logic clr_t;
    assign clr_t = bus_wr && (bus_addr == OFF_CLR) && bus_wdata[TIME_BIT];

    AST_STOP_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == OFF_CTL && bus_wdata[CTL_STOP_BIT]) |=> !run); // R2
    AST_TIME_INC: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !clr_t) |=> (tcnt == CNT_W'($past(tcnt) + 1'b1))); // R4
    AST_HOLD_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !clr_t) |=> $stable(tcnt)); // R6
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (tovf && !clr_t) |=> tovf); // R7
    AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        clr_t |=> (tcnt == '0 && !tovf)); // R9
    AST_SIG_CONST: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == OFF_SIG) |-> (bus_rdata == SIG_VAL)); // R10
    AST_IRQ_HOLE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr >= 10'h010 && bus_addr <= 10'h01B) |-> (bus_rdata == '0)); // R11
endmodule

bind dram_perf_monitor dpm_checker #(.CNT_W(CNT_W)) u_dpm_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .run       (run),
    .tcnt      (time_cnt),
    .tovf      (time_ovf)
);

// File: tb/test_dram_perf_monitor.sv
module test_dram_perf_monitor;
    localparam int CLK_PERIOD = 10;
    localparam int TB_CW = 12;
    localparam int NE = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [9:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [NE-1:0] ev_pulse = '0;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    logic [TB_CW-1:0] m_cnt [5];
    logic             m_ovf [5];
    logic             m_run;
    logic [NE-1:0]    m_en;

    always #(CLK_PERIOD/2) clk = ~clk;

    dram_perf_monitor #(.NUM_EVT(NE), .CNT_W(TB_CW)) i_dram_perf_monitor (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ev_pulse(ev_pulse));

    // Reference model: index 4 is the time counter
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < 5; k++) begin
                m_cnt[k] <= '0;
                m_ovf[k] <= 1'b0;
            end
            m_run <= 1'b0;
            m_en  <= '0;
        end else begin
            if (bus_wr && bus_addr == 10'h000) begin
                if (bus_wdata[0]) m_run <= 1'b1;
                if (bus_wdata[1]) m_run <= 1'b0;
            end
            if (bus_wr && bus_addr == 10'h004) m_en <= bus_wdata[NE-1:0];
            for (int k = 0; k < 5; k++) begin
                if (bus_wr && bus_addr == 10'h00C && bus_wdata[(k == 4) ? 31 : k]) begin
                    m_cnt[k] <= '0;
                    m_ovf[k] <= 1'b0;
                end else if (m_run && (k == 4 || (m_en[k] && ev_pulse[k]))) begin
                    m_cnt[k] <= m_cnt[k] + 1'b1;
                    if (&m_cnt[k]) m_ovf[k] <= 1'b1;
                end
            end
        end
    end

    function automatic logic [31:0] exp_rd(input logic [9:0] a);
        logic [31:0] v;
        v = '0;
        case (a)
            10'h000: v[0] = m_run;
            10'h004: v[NE-1:0] = m_en;
            10'h008: begin
                v[31] = m_ovf[4];
                for (int k = 0; k < NE; k++) v[k] = m_ovf[k];
            end
            10'h020: v = 32'(m_cnt[4]);
            10'h030: v = 32'(m_cnt[0]);
            10'h038: v = 32'(m_cnt[1]);
            10'h040: v = 32'(m_cnt[2]);
            10'h048: v = 32'(m_cnt[3]);
            10'h3F0: v = 32'(NE) | (32'(TB_CW) << 8);
            10'h3F4: v = 32'h0000_0100;
            10'h3F8: v = 32'h0000_0DD5;
            10'h3FC: v = 32'hA3C5_DD01;
            default: v = '0;
        endcase
        return v;
    endfunction

    function automatic string req_of(input logic [9:0] a);
        case (a)
            10'h000: return "R2";
            10'h004: return "R3";
            10'h008: return "R7";
            10'h020: return "R4";
            10'h030, 10'h038, 10'h040, 10'h048: return "R5";
            10'h3F0, 10'h3F4, 10'h3F8, 10'h3FC: return "R10";
            default: return "R11";
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s addr=%h actual=%h expected=%h", req, bus_addr, act, exp);
        end
    endtask

    // One cycle: drive at negedge, compare combinational read against model
    task automatic step(input logic wr, input logic [9:0] a, input logic [31:0] d,
                        input logic [NE-1:0] ev);
        @(negedge clk);
        bus_wr = wr; bus_addr = a; bus_wdata = d; ev_pulse = ev;
        #1;
        check(req_of(a), bus_rdata, exp_rd(a));
    endtask

    task automatic rd_lit(input logic [9:0] a, input logic [31:0] exp, input string req);
        @(negedge clk);
        bus_wr = 1'b0; bus_addr = a; ev_pulse = '0;
        #1;
        check(req, bus_rdata, exp);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        failures++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [9:0] rd_list [13];
        rd_list = '{10'h000, 10'h004, 10'h008, 10'h020, 10'h030, 10'h038, 10'h040,
                    10'h048, 10'h010, 10'h014, 10'h018, 10'h100, 10'h3F0};
        void'($urandom(32'd4711));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        rd_lit(10'h000, 32'h0, "R1");
        rd_lit(10'h004, 32'h0, "R1");
        rd_lit(10'h008, 32'h0, "R1");
        rd_lit(10'h020, 32'h0, "R1");
        rd_lit(10'h048, 32'h0, "R1");
        // R10: constants
        rd_lit(10'h3FC, 32'hA3C5_DD01, "R10");
        rd_lit(10'h3F0, 32'h0000_0C04, "R10");
        rd_lit(10'h3F4, 32'h0000_0100, "R10");
        rd_lit(10'h3F8, 32'h0000_0DD5, "R10");

        // R3: enables read back, upper bits dropped
        step(1'b1, 10'h004, 32'hFFFF_FFF5, '0);
        rd_lit(10'h004, 32'h0000_0005, "R3");
        // R2: start+stop together, stop wins
        step(1'b1, 10'h000, 32'h3, '0);
        rd_lit(10'h000, 32'h0, "R2");
        rd_lit(10'h020, 32'h0, "R6");

        // R7: everything wraps
        step(1'b1, 10'h004, 32'hF, '0);
        step(1'b1, 10'h000, 32'h1, '0);
        for (int i = 0; i < (1 << TB_CW) + 4; i++) step(1'b0, 10'h008, 32'h0, 4'hF);
        rd_lit(10'h008, 32'h8000_000F, "R7");
        // R11: ignored write to the interrupt hole
        step(1'b1, 10'h010, 32'hFFFF_FFFF, 4'h0);
        rd_lit(10'h010, 32'h0, "R11");
        rd_lit(10'h004, 32'h0000_000F, "R11");
        // R9: clear counter 2 while its pulse is high
        step(1'b1, 10'h00C, 32'h0000_0004, 4'hF);
        rd_lit(10'h040, 32'h0, "R9");
        rd_lit(10'h008, 32'h8000_000B, "R9");
        // R6: stopped counters hold
        step(1'b1, 10'h000, 32'h2, 4'hF);
        step(1'b0, 10'h030, 32'h0, 4'hF);
        begin
            logic [31:0] held;
            held = bus_rdata;
            repeat (5) step(1'b0, 10'h030, 32'h0, 4'hF);
            rd_lit(10'h030, held, "R6");
        end
        // R8: selective clear
        step(1'b1, 10'h00C, 32'h8000_0001, 4'h0);
        rd_lit(10'h020, 32'h0, "R8");
        rd_lit(10'h030, 32'h0, "R8");
        rd_lit(10'h008, 32'h0000_000A, "R8");

        // Random phase, checked against the model (R4, R5 and the rest)
        for (int i = 0; i < 12000; i++) begin
            int sel;
            logic [31:0] d;
            logic [9:0] a;
            sel = int'($urandom_range(0, 99));
            d = $urandom;
            a = rd_list[$urandom_range(0, 12)];
            if (sel < 2)       step(1'b1, 10'h000, d & 32'h3, 4'($urandom));
            else if (sel < 4)  step(1'b1, 10'h004, d, 4'($urandom));
            else if (sel < 5)  step(1'b1, 10'h00C, d & 32'h8000_000F, 4'($urandom));
            else if (sel < 7)  step(1'b1, 10'h010 + 10'(4 * $urandom_range(0, 2)), d, 4'($urandom));
            else if (sel < 8)  step(1'b1, 10'h2A0, d, 4'($urandom));
            else if (sel < 10) step(1'b1, 10'h000, 32'h1, 4'($urandom));
            else               step(1'b0, a, 32'h0, 4'($urandom));
        end
        finish_run();
    end
endmodule